// File: doc/BRIEF.md
# Timer Event Status Register with Read-Then-Clear Flags

This block collects event flags from three timer channels into one 16-bit status word. Each channel has one overflow flag and four capture/compare flags, one for each of its units A to D. The channel logic sits outside the block and signals each event with a single-cycle pulse. That pulse sets the matching flag, and the flag stays set until software clears it.

Software reads the word over a simple register port. It can clear a flag only by reading it as 1 and then writing 0 to that bit. A read that returns 1 arms the bit, and only a write of 0 to an armed bit clears the flag. Writing 1 never sets or clears anything. This stops a write that follows a stale read from losing an event.

Each flag also drives a level interrupt request: the flag ANDed with its enable bit. Software loads the enable mask through a separate write strobe.

Top module: `tsf_status_reg`

## Requirements
- R1: Bit 15 is reserved. It always reads 0, writes to it have no effect, and its interrupt request stays 0.
- R2: Bit layout: for channel k (0, 1, 2), the overflow flag is at bit 5k+4 and units A, B, C, D are at bits 5k+0 to 5k+3. Event input `cap_evt[4k+u]` is unit u (A=0 to D=3) of channel k, and `ovf_evt[k]` is the overflow of channel k.
- R3: After reset, all flags, arm bits and enables are 0, so `rd_data` and `irq` are 0.
- R4: An event pulse sampled on a rising edge sets its flag, and `rd_data` shows the flag from that edge on.
- R5: A bit is armed on an edge where `rd_en` is high and that bit's flag is 1. On a later edge with `wr_en` high and that data bit 0, an armed flag clears and its arm bit is consumed.
- R6: Writing 1 to a flag bit has no effect. A clear flag stays clear, a set flag stays set, and a set flag stays armed.
- R7: A flag that was 0 when read is not armed. A write of 0 leaves it set even if an event set it after the read.
- R8: If a set event and an armed clear land on the same edge, the flag stays 1. The arm bit is still consumed, so a second write of 0 without a new read leaves the flag set.
- R9: `irq[i]` is flag i AND enable i, as a level. The enable mask is loaded from `ien_data` on an edge with `ien_wr` high.
- R10: A clear acts per bit. An armed bit written 1 keeps both its flag and its arm, so a later write of 0 clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ovf_evt | input | 3 | Overflow event pulse, one per channel |
| cap_evt | input | 12 | Capture/compare event pulse, index 4*channel+unit |
| rd_en | input | 1 | Read strobe; arms every bit that reads 1 |
| rd_data | output | 16 | Current flag word |
| wr_en | input | 1 | Write strobe for clearing flags |
| wr_data | input | 16 | Write data; 0 clears an armed bit |
| ien_wr | input | 1 | Enable-mask load strobe |
| ien_data | input | 16 | Enable-mask value |
| irq | output | 16 | Per-flag level interrupt request |

## Verification
The assertions assume each event input is a clean synchronous level sampled once per edge. A pulse held for several cycles simply sets the flag again on each of those edges, and no property depends on the pulse lasting exactly one cycle. The assertions also treat `rd_en` and `wr_en` in the same cycle as legal. In that case the write acts on the arm state from before the read. The bench drives every input on the falling edge and holds it for exactly one cycle. It overlaps an event with a write only in the priority test, and it never overlaps a read with a write.

// File: rtl/tsf_pkg.sv
// Package: shared sizing and bit-position helpers for the timer status register.
// Assumes each channel packs its unit flags low and its overflow flag just above them.
package tsf_pkg;
    localparam int TSF_NUM_CH    = 3;
    localparam int TSF_NUM_UNITS = 4;

    // Bit position of unit u of channel ch.
    function automatic int unit_bit(input int ch, input int u, input int units);
        return ch * (units + 1) + u;
    endfunction

    // Bit position of the overflow flag of channel ch.
    function automatic int ovf_bit(input int ch, input int units);
        return ch * (units + 1) + units;
    endfunction
endpackage

// File: rtl/tsf_event_map.sv
// Module: tsf_event_map
// Routes the per-channel event pulses to their positions in the status word.
// Assumes the top bit of the word is reserved and never receives an event.
module tsf_event_map #(
    parameter int NUM_CH    = 3,
    parameter int NUM_UNITS = 4,
    localparam int REG_W    = NUM_CH * (NUM_UNITS + 1) + 1
) (
    input  logic [NUM_CH-1:0]           ovf_evt,
    input  logic [NUM_CH*NUM_UNITS-1:0] cap_evt,
    output logic [REG_W-1:0]            set_vec
);
    import tsf_pkg::*;

    // Wire every channel's events to its field; the reserved bit is tied low.
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
            assign set_vec[unit_bit(ch, u, NUM_UNITS)] = cap_evt[ch*NUM_UNITS + u];
        end
        assign set_vec[ovf_bit(ch, NUM_UNITS)] = ovf_evt[ch];
    end
    assign set_vec[REG_W-1] = 1'b0;
endmodule

// File: rtl/tsf_flag_cell.sv
// Module: tsf_flag_cell
// One status flag and its arm bit. A read that sees the flag set arms the bit.
// A write of 0 to an armed bit consumes the arm and clears the flag,
// unless a set event arrives on the same edge, in which case the set wins.
// Assumes clr_wr_i is the write strobe already qualified by a 0 data bit.
module tsf_flag_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic rd_i,
    input  logic clr_wr_i,
    output logic flag_o,
    output logic arm_o
);
    // Update the flag and arm state on each edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_o <= 1'b0;
            arm_o  <= 1'b0;
        end else if (clr_wr_i && arm_o) begin
            flag_o <= set_i;
            arm_o  <= 1'b0;
        end else begin
            if (set_i)
                flag_o <= 1'b1;
            if (rd_i && flag_o)
                arm_o <= 1'b1;
        end
    end
endmodule

// File: rtl/tsf_status_reg.sv
// Module: tsf_status_reg (top)
// Status word for several timer channels, with flags that clear only after
// a read of 1 followed by a write of 0, and one level interrupt per flag.
// Assumes event inputs are synchronous to clk. The top bit is reserved.
module tsf_status_reg #(
    parameter int NUM_CH    = tsf_pkg::TSF_NUM_CH,
    parameter int NUM_UNITS = tsf_pkg::TSF_NUM_UNITS,
    localparam int REG_W    = NUM_CH * (NUM_UNITS + 1) + 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_CH-1:0]           ovf_evt,
    input  logic [NUM_CH*NUM_UNITS-1:0] cap_evt,
    input  logic                        rd_en,
    output logic [REG_W-1:0]            rd_data,
    input  logic                        wr_en,
    input  logic [REG_W-1:0]            wr_data,
    input  logic                        ien_wr,
    input  logic [REG_W-1:0]            ien_data,
    output logic [REG_W-1:0]            irq
);
    logic [REG_W-1:0] set_vec;
    logic [REG_W-1:0] flag_vec;
    logic [REG_W-1:0] arm_vec;
    logic [REG_W-1:0] ien_q;

    tsf_event_map #(.NUM_CH(NUM_CH), .NUM_UNITS(NUM_UNITS)) u_map (
        .ovf_evt (ovf_evt),
        .cap_evt (cap_evt),
        .set_vec (set_vec)
    );

    // One flag cell per implemented bit; the reserved bit holds no state.
    for (genvar i = 0; i < REG_W - 1; i++) begin : g_cell
        tsf_flag_cell u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .set_i    (set_vec[i]),
            .rd_i     (rd_en),
            .clr_wr_i (wr_en && !wr_data[i]),
            .flag_o   (flag_vec[i]),
            .arm_o    (arm_vec[i])
        );
    end
    assign flag_vec[REG_W-1] = 1'b0;
    assign arm_vec[REG_W-1]  = 1'b0;

    // Hold the interrupt enable mask, with the reserved bit forced low.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ien_q <= '0;
        else if (ien_wr)
            ien_q <= {1'b0, ien_data[REG_W-2:0]};
    end

    assign rd_data = flag_vec;
    assign irq     = flag_vec & ien_q;
endmodule

// File: rtl/tsf_checker.sv
// Module: tsf_checker
// Properties on the flag protocol, attached to every tsf_status_reg instance.
// Assumes it sees the internal set and arm vectors through the bind ports.
module tsf_checker #(
    parameter int REG_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [REG_W-1:0] set_vec,
    input logic [REG_W-1:0] arm_vec,
    input logic [REG_W-1:0] rd_data,
    input logic             wr_en,
    input logic [REG_W-1:0] wr_data,
    input logic [REG_W-1:0] irq
);
    for (genvar i = 0; i < REG_W - 1; i++) begin : g_bit
        AST_EVENT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
            set_vec[i] |=> rd_data[i]); // R4
        AST_WRITE_ONE_INERT: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_data[i] && !set_vec[i] && !rd_data[i]) |=> !rd_data[i]); // R6
        AST_UNARMED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && !wr_data[i] && rd_data[i] && !arm_vec[i]) |=> rd_data[i]); // R7
        AST_ARMED_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && !wr_data[i] && arm_vec[i] && !set_vec[i]) |=> !rd_data[i]); // R5
        AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
            irq[i] |-> rd_data[i]); // R9
    end
endmodule

bind tsf_status_reg tsf_checker #(.REG_W(REG_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (set_vec),
    .arm_vec (arm_vec),
    .rd_data (rd_data),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .irq     (irq)
);

// File: tb/tb_tsf_status_reg.sv
module tb_tsf_status_reg;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  ovf_evt = '0;
    logic [11:0] cap_evt = '0;
    logic        rd_en = 1'b0;
    logic [15:0] rd_data;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic        ien_wr = 1'b0;
    logic [15:0] ien_data = '0;
    logic [15:0] irq;
    int errors = 0;
    int checks = 0;

    always #2 clk = ~clk;

    tsf_status_reg dut (
        .clk(clk), .rst_n(rst_n), .ovf_evt(ovf_evt), .cap_evt(cap_evt),
        .rd_en(rd_en), .rd_data(rd_data), .wr_en(wr_en), .wr_data(wr_data),
        .ien_wr(ien_wr), .ien_data(ien_data), .irq(irq)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive every input for one cycle from a falling edge, then idle.
    task automatic step(input logic rd, input logic wr, input logic [15:0] wd,
                        input logic [2:0] ov, input logic [11:0] cp);
        @(negedge clk);
        rd_en = rd; wr_en = wr; wr_data = wd; ovf_evt = ov; cap_evt = cp;
        @(negedge clk);
        rd_en = 1'b0; wr_en = 1'b0; wr_data = '0; ovf_evt = '0; cap_evt = '0;
        #1;
    endtask

    task automatic rd();                        step(1'b1, 1'b0, 16'h0, 3'b0, 12'h0); endtask
    task automatic wr(input logic [15:0] d);    step(1'b0, 1'b1, d, 3'b0, 12'h0);     endtask
    task automatic ev(input logic [2:0] o, input logic [11:0] c); step(1'b0, 1'b0, 16'h0, o, c); endtask
    task automatic clear_all(); rd(); wr(16'h0000); endtask

    task automatic t_reset();
        check("R3 flags", rd_data, 16'h0000);
        check("R3 irq", irq, 16'h0000);
    endtask

    task automatic t_layout();
        ev(3'b100, 12'h0);
        check("R2 ovf ch2 -> bit14", rd_data, 16'h4000);
        clear_all();
        ev(3'b000, 12'h080);
        check("R2 ch1 unit D -> bit8", rd_data, 16'h0100);
        clear_all();
        ev(3'b001, 12'h004);
        check("R4 ovf ch0 + ch0 unit C", rd_data, 16'h0014);
        clear_all();
        check("R5 cleared", rd_data, 16'h0000);
        wr(16'hFFFF);
        check("R1 reserved bit reads 0", rd_data, 16'h0000);
        @(negedge clk); ien_wr = 1'b1; ien_data = 16'h8000;
        @(negedge clk); ien_wr = 1'b0; #1;
        check("R1 reserved irq 0", irq, 16'h0000);
    endtask

    task automatic t_clear();
        ev(3'b0, 12'h001);
        rd();
        wr(16'hFFFE);
        check("R5 armed write 0 clears", rd_data, 16'h0000);
    endtask

    task automatic t_write1();
        wr(16'hFFFF);
        check("R6 write 1 never sets", rd_data, 16'h0000);
        ev(3'b0, 12'h001);
        rd();
        wr(16'hFFFF);
        check("R6 write 1 keeps flag", rd_data, 16'h0001);
        wr(16'hFFFE);
        check("R6 arm kept through write 1", rd_data, 16'h0000);
    endtask

    task automatic t_unarmed();
        rd();
        ev(3'b0, 12'h008);
        wr(16'hFFF7);
        check("R7 unarmed write 0 ignored", rd_data, 16'h0008);
        clear_all();
        check("R7 cleanup", rd_data, 16'h0000);
    endtask

    task automatic t_collision();
        ev(3'b001, 12'h0);
        rd();
        step(1'b0, 1'b1, 16'hFFEF, 3'b001, 12'h0);
        check("R8 set beats clear", rd_data, 16'h0010);
        wr(16'hFFEF);
        check("R8 arm consumed", rd_data, 16'h0010);
        clear_all();
        check("R8 cleanup", rd_data, 16'h0000);
    endtask

    task automatic t_irq();
        @(negedge clk); ien_wr = 1'b1; ien_data = 16'h0200;
        @(negedge clk); ien_wr = 1'b0; #1;
        check("R9 no flag no irq", irq, 16'h0000);
        ev(3'b010, 12'h0);
        ev(3'b000, 12'h001);
        check("R9 irq follows enabled flag", irq, 16'h0200);
        @(negedge clk); ien_wr = 1'b1; ien_data = 16'h0000;
        @(negedge clk); ien_wr = 1'b0; #1;
        check("R9 irq drops when disabled", irq, 16'h0000);
        check("R9 flags unchanged", rd_data, 16'h0201);
        clear_all();
    endtask

    task automatic t_indep();
        ev(3'b0, 12'h003);
        rd();
        wr(16'hFFFE);
        check("R10 only bit0 cleared", rd_data, 16'h0002);
        wr(16'hFFFD);
        check("R10 bit1 still armed", rd_data, 16'h0000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        t_layout();
        t_clear();
        t_write1();
        t_unarmed();
        t_collision();
        t_irq();
        t_indep();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #40000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule